// File: doc/BRIEF.md
# Per-Pixel Overlay Alpha Blender

This block mixes two YCbCr component streams, a main video stream and an overlay stream, one pixel at a time. For each pixel a 2-bit blend code selects one of four programmable 4-bit weights W. The three components are each blended as (W·overlay + (15−W)·video)/15, rounded to nearest. The blend code comes from one of two places. It can come from a dedicated 2-bit alpha pin bus that is sampled on every clock. It can also come from the two least significant bits of the overlay luma sample, so an overlay source can carry its own transparency inside its pixel data.

The weight table is written through a simple one-entry-per-cycle write port. A write is seen by the pixel presented on the clock after the write. The result appears two clocks after its inputs are presented, together with a valid flag that is delayed by the same amount.

Top module: `ovl_alpha_blend`

## Requirements
- R1: After reset the four weight entries hold 0x0, 0xA, 0xF and 0xF for codes 0, 1, 2 and 3.
- R2: When `pin_mode_i` is 1, the weight is selected by `alpha_i` (code 0..3).
- R3: When `pin_mode_i` is 0, the weight is selected by `ovl_y_i[1:0]` (code 0..3).
- R4: Each output component equals (W·ovl + (15−W)·vid + 7) / 15 with integer division, where W is the 4-bit selected weight.
- R5: A weight of 0 passes the video component unchanged, and a weight of 15 passes the overlay component unchanged.
- R6: Outputs and `valid_o` change on the second rising clock edge after the inputs are presented. `valid_o` reproduces `valid_i` delayed by two clocks and is 0 during and after reset until then. Outputs are 0 after reset.
- R7: A table write (`lut_we_i`=1, `lut_addr_i`, `lut_wdata_i`) does not change the weight used by the pixel presented in the same cycle. It applies to every pixel presented from the next cycle on.
- R8: The blend code is taken fresh on every clock, so consecutive samples may use different weights.
- R9: Every output component lies between the video and overlay values it was blended from, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input pixel valid |
| vid_y_i | input | 8 | Video luma |
| vid_cb_i | input | 8 | Video Cb |
| vid_cr_i | input | 8 | Video Cr |
| ovl_y_i | input | 8 | Overlay luma (low bits are the code in luma-code mode) |
| ovl_cb_i | input | 8 | Overlay Cb |
| ovl_cr_i | input | 8 | Overlay Cr |
| alpha_i | input | 2 | Blend code from pins |
| pin_mode_i | input | 1 | 1: code from alpha_i, 0: code from ovl_y_i[1:0] |
| lut_we_i | input | 1 | Weight table write enable |
| lut_addr_i | input | 2 | Weight table entry to write |
| lut_wdata_i | input | 4 | Weight value to write |
| y_o | output | 8 | Blended luma |
| cb_o | output | 8 | Blended Cb |
| cr_o | output | 8 | Blended Cr |
| valid_o | output | 1 | Output valid |

## Verification
A table write and a pixel lookup can fall in the same cycle. The bench provokes this by writing an entry while a pixel addresses that same entry. Its scoreboard expects the old weight for that pixel and the new weight for the next one. The code source switch and a changing pin code can also coincide with writes. Each cycle's expected result is computed from the bench's own copy of the table taken before that cycle's write is applied, and it is compared two clocks later.

// File: rtl/ovl_blend_pkg.sv
package ovl_blend_pkg;
  localparam int unsigned CW = 8;
  localparam int unsigned WW = 4;
  localparam int unsigned IW = 2;
  localparam int unsigned NE = 1 << IW;
  localparam logic [NE*WW-1:0] TBL_RST = 16'hFFA0; // entry 0 in the low nibble
endpackage

// File: rtl/ovl_weight_lut.sv
module ovl_weight_lut
  import ovl_blend_pkg::*;
#(
  parameter int unsigned IDX_W = IW,
  parameter int unsigned WGT_W = WW,
  parameter logic [(1<<IDX_W)*WGT_W-1:0] RST_TBL = TBL_RST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [WGT_W-1:0] wdata_i,
  input  logic             pin_mode_i,
  input  logic [IDX_W-1:0] pin_idx_i,
  input  logic [IDX_W-1:0] luma_idx_i,
  output logic [WGT_W-1:0] wgt_o
);
  localparam int unsigned N = 1 << IDX_W;

  logic [WGT_W-1:0] tbl [N];
  logic [IDX_W-1:0] idx;

  for (genvar e = 0; e < N; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         tbl[e] <= RST_TBL[e*WGT_W +: WGT_W];
      else if (we_i && waddr_i == IDX_W'(e)) tbl[e] <= wdata_i;
    end
  end

  assign idx   = pin_mode_i ? pin_idx_i : luma_idx_i;
  assign wgt_o = tbl[idx];

  p_wr_lands_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ovl_blend_lane.sv
module ovl_blend_lane
  import ovl_blend_pkg::*;
#(
  parameter int unsigned DW = CW,
  parameter int unsigned WGT_W = WW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WGT_W-1:0] wgt_i,
  input  logic [DW-1:0]    vid_i,
  input  logic [DW-1:0]    ovl_i,
  output logic [DW-1:0]    res_o
);
  localparam int unsigned WMAX = (1 << WGT_W) - 1;
  localparam int unsigned AW   = DW + WGT_W + 1;

  logic [WGT_W-1:0] wgt_q;
  logic [DW-1:0]    vid_q, ovl_q;
  logic [AW-1:0]    acc, quo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wgt_q <= '0;
      vid_q <= '0;
      ovl_q <= '0;
    end else begin
      wgt_q <= wgt_i;
      vid_q <= vid_i;
      ovl_q <= ovl_i;
    end
  end

  always_comb begin
    acc = AW'(wgt_q) * AW'(ovl_q)
        + AW'(WGT_W'(WMAX) - wgt_q) * AW'(vid_q)
        + AW'(WMAX / 2);
    quo = acc / AW'(WMAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_o <= '0;
    else         res_o <= quo[DW-1:0];
  end

  p_w0_video_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wgt_q == '0) |=> res_o == $past(vid_q));
  p_wmax_ovl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wgt_q == WGT_W'(WMAX)) |=> res_o == $past(ovl_q));
  p_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (res_o >= (($past(vid_q) < $past(ovl_q)) ? $past(vid_q) : $past(ovl_q)))
          && (res_o <= (($past(vid_q) < $past(ovl_q)) ? $past(ovl_q) : $past(vid_q))));
endmodule

// File: rtl/ovl_alpha_blend.sv
module ovl_alpha_blend
  import ovl_blend_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [CW-1:0] vid_y_i,
  input  logic [CW-1:0] vid_cb_i,
  input  logic [CW-1:0] vid_cr_i,
  input  logic [CW-1:0] ovl_y_i,
  input  logic [CW-1:0] ovl_cb_i,
  input  logic [CW-1:0] ovl_cr_i,
  input  logic [IW-1:0] alpha_i,
  input  logic          pin_mode_i,
  input  logic          lut_we_i,
  input  logic [IW-1:0] lut_addr_i,
  input  logic [WW-1:0] lut_wdata_i,
  output logic [CW-1:0] y_o,
  output logic [CW-1:0] cb_o,
  output logic [CW-1:0] cr_o,
  output logic          valid_o
);
  localparam int unsigned NC = 3;

  logic [WW-1:0] wgt;
  logic [CW-1:0] vid_c [NC];
  logic [CW-1:0] ovl_c [NC];
  logic [CW-1:0] res_c [NC];
  logic [1:0]    vld_q;

  assign vid_c[0] = vid_y_i;  assign ovl_c[0] = ovl_y_i;
  assign vid_c[1] = vid_cb_i; assign ovl_c[1] = ovl_cb_i;
  assign vid_c[2] = vid_cr_i; assign ovl_c[2] = ovl_cr_i;

  ovl_weight_lut u_lut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (lut_we_i),
    .waddr_i    (lut_addr_i),
    .wdata_i    (lut_wdata_i),
    .pin_mode_i (pin_mode_i),
    .pin_idx_i  (alpha_i),
    .luma_idx_i (ovl_y_i[IW-1:0]),
    .wgt_o      (wgt)
  );

  for (genvar c = 0; c < NC; c++) begin : g_lane
    ovl_blend_lane u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wgt_i  (wgt),
      .vid_i  (vid_c[c]),
      .ovl_i  (ovl_c[c]),
      .res_o  (res_c[c])
    );
  end

  assign y_o  = res_c[0];
  assign cb_o = res_c[1];
  assign cr_o = res_c[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[0], valid_i};
  end
  assign valid_o = vld_q[1];

  p_vld_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  p_vld_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);
endmodule

// File: tb/ovl_alpha_blend_test.sv
module ovl_alpha_blend_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] vy = '0, vcb = '0, vcr = '0, oy = '0, ocb = '0, ocr = '0;
  logic [1:0] alpha = '0;
  logic       pmode = 1'b1;
  logic       we = 1'b0;
  logic [1:0] waddr = '0;
  logic [3:0] wdata = '0;
  logic [7:0] y_o, cb_o, cr_o;
  logic       valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit       v;
    int       y, cb, cr;
    string    tag;
  } exp_t;
  exp_t q[$];
  int tbl [4] = '{0, 10, 15, 15};

  always #10 clk = ~clk;

  ovl_alpha_blend uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .vid_y_i(vy), .vid_cb_i(vcb), .vid_cr_i(vcr),
    .ovl_y_i(oy), .ovl_cb_i(ocb), .ovl_cr_i(ocr),
    .alpha_i(alpha), .pin_mode_i(pmode),
    .lut_we_i(we), .lut_addr_i(waddr), .lut_wdata_i(wdata),
    .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o), .valid_o(valid_o)
  );

  function automatic int mix(int w, int o, int v);
    return (w * o + (15 - w) * v + 7) / 15;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one pixel per cycle; expectation uses table state before this cycle's write
  task automatic drive(string tag, bit v, bit m, int a,
                       int y0, int b0, int r0, int y1, int b1, int r1,
                       bit w = 0, int wa = 0, int wd = 0);
    exp_t e;
    int   wt;
    @(negedge clk);
    valid_i = v; pmode = m; alpha = 2'(a);
    vy = 8'(y0); vcb = 8'(b0); vcr = 8'(r0);
    oy = 8'(y1); ocb = 8'(b1); ocr = 8'(r1);
    we = w; waddr = 2'(wa); wdata = 4'(wd);
    wt = m ? tbl[a] : tbl[y1 & 3];
    e.v = v; e.tag = tag;
    e.y = mix(wt, y1, y0); e.cb = mix(wt, b1, b0); e.cr = mix(wt, r1, r0);
    q.push_back(e);
    if (w) tbl[wa] = wd;
  endtask

  // monitor: compares the item driven two edges earlier
  initial begin
    exp_t e;
    @(posedge rst_n);
    forever begin
      @(posedge clk); #5;
      if (q.size() >= 2) begin
        e = q.pop_front();
        check({e.tag, " valid (R6)"}, int'(valid_o), int'(e.v));
        if (e.v) begin
          check({e.tag, " y"},  int'(y_o),  e.y);
          check({e.tag, " cb"}, int'(cb_o), e.cb);
          check({e.tag, " cr"}, int'(cr_o), e.cr);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R6 reset valid", int'(valid_o), 0);
    check("R6 reset y", int'(y_o), 0);
    check("R6 reset cb", int'(cb_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: reset table through pin codes
    for (int a = 0; a < 4; a++)
      drive("R1 R2 default entry", 1, 1, a, 200, 30, 90, 40, 220, 160);
    // R5: pure video / pure overlay
    drive("R5 w0 video", 1, 1, 0, 17, 250, 3, 99, 1, 200);
    drive("R5 w15 overlay", 1, 1, 2, 17, 250, 3, 99, 1, 200);
    drive("R6 idle", 0, 1, 1, 5, 5, 5, 9, 9, 9);
    // R4: rounding with W=10
    drive("R4 round", 1, 1, 1, 1, 0, 255, 0, 1, 254);
    drive("R4 round", 1, 1, 1, 128, 7, 100, 131, 200, 101);
    // R3: luma-code mode, pins contradict
    for (int c = 0; c < 4; c++)
      drive("R3 luma code", 1, 0, 3 - c, 60, 70, 80, 200 + c, 10, 240);
    // R7: write entry 0 while a pixel uses entry 0
    drive("R7 same-cycle old", 1, 1, 0, 100, 100, 100, 250, 0, 50, 1, 0, 7);
    drive("R7 next-cycle new", 1, 1, 0, 100, 100, 100, 250, 0, 50);
    drive("R7 write entry3 luma", 1, 0, 0, 10, 20, 30, 243, 2, 9, 1, 3, 4);
    drive("R7 entry3 new", 1, 0, 0, 10, 20, 30, 243, 2, 9);
    // R8: code changes every sample
    for (int i = 0; i < 16; i++)
      drive("R8 per-sample code", 1, 1, i % 4, 3 * i, 255 - i, 128, 250 - 5 * i, i, 7 * i);
    // R9 plus mixed patterns, writes interleaved
    for (int i = 0; i < 60; i++)
      drive("R9 R4 mixed", (i % 7) != 3, (i % 3) != 0, int'($urandom_range(0, 3)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            (i % 5) == 0, int'($urandom_range(0, 3)), int'($urandom_range(0, 15)));
    for (int i = 0; i < 3; i++)
      drive("R6 flush", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    @(posedge clk); #6;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule